// File: doc/BRIEF.md
# Pipelined Control Decoder with Stage-Sliced Control Registers

This block is the control path of a five-stage in-order integer pipeline. In the decode stage it looks at the 6-bit opcode and the 6-bit function field of the instruction. From these it derives the control bits that the later stages need. The bits are sorted by the stage that consumes them: execute, memory and write-back. They then ride along with the instruction through the three control registers that sit between those stages.

Each group leaves the control pipe at the stage that uses it. As a result the registers get narrower toward the end of the pipe:

- The decode/execute register holds all three groups plus the function field.
- The execute/memory register holds the memory and write-back groups plus the captured zero flag.
- The memory/write-back register holds the write-back group only.

In the execute stage, a second decoder turns the 2-bit ALU class and the carried function field into a 4-bit ALU operation code. In the memory stage, the branch-taken select is formed from the branch bit and the ALU zero flag. The zero flag was captured when the branch left execute. Fetch and decode need no per-instruction controls.

Top module: `pctl_top`

## Requirements
- R1: Opcode 000000 (register-register) gives, in execute, reg_dst=1, alu_op=10 and alu_src=0. In memory it gives branch=0, read=0 and write=0. In write-back it gives reg_write=1 and mem_to_reg=0.
- R2: Opcode 100011 (load) gives reg_dst=0, alu_op=00 and alu_src=1. It gives branch=0, read=1 and write=0. It gives reg_write=1 and mem_to_reg=1.
- R3: Opcode 101011 (store) gives alu_op=00, alu_src=1 and write=1. Every other control bit is 0, including reg_dst and mem_to_reg.
- R4: Opcode 000100 (branch-if-equal) gives alu_op=01 and branch=1. Every other control bit is 0.
- R5: Any other opcode gives all control bits 0 in every stage, so the instruction acts as a no-op.
- R6: When alu_op is 00, ex_alu_ctl is 0010 (add). When alu_op is 01, ex_alu_ctl is 0110 (subtract).
- R7: When alu_op is 10, the function field selects the ALU code: 100000 gives 0010, 100010 gives 0110, 100100 gives 0000, 100101 gives 0001 and 101010 gives 0111. Any other function value gives 1111.
- R8: The function field has no effect on ex_alu_ctl unless alu_op is 10.
- R9: The controls decoded while an instruction is in decode appear on the execute outputs after one rising clock edge. They appear on the memory outputs after two edges and on the write-back outputs after three. A new instruction may enter every cycle, and each stage shows only its own instruction's controls.
- R10: mem_pcsrc is 1 exactly when the memory-stage branch bit is 1 and ex_zero was 1 during the cycle that instruction spent in execute. The zero flag has no effect for instructions that are not branches.
- R11: An active-low asynchronous reset clears every stage's control bits to 0 at once. While the reset is held, ex_alu_ctl reads 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_opcode | input | 6 | Opcode of the instruction in decode |
| id_funct | input | 6 | Function field of the instruction in decode |
| ex_zero | input | 1 | ALU zero flag of the instruction in execute |
| ex_reg_dst | output | 1 | Destination register from rd (1) or rt (0) |
| ex_alu_op | output | 2 | ALU class of the instruction in execute |
| ex_alu_src | output | 1 | Second ALU operand is the immediate (1) or the rt value (0) |
| ex_alu_ctl | output | 4 | Decoded ALU operation code |
| mem_branch | output | 1 | Instruction in memory is a conditional branch |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| mem_pcsrc | output | 1 | Take the branch target as the next PC |
| wb_reg_write | output | 1 | Register file write enable |
| wb_mem_to_reg | output | 1 | Write-back data from memory (1) or the ALU (0) |

## Verification
Decoding a new instruction in decode and retiring older instructions in execute, memory and write-back all happen in the same cycle. So does the branch decision in memory, which must use the zero flag captured one cycle earlier, not the current one. The bench issues a different instruction into decode on every cycle, back to back. It drives ex_zero with the flag meant for whichever instruction is in execute at that moment. After each edge it compares all three stage output groups and mem_pcsrc against the expected values of the three different instructions in flight. A mis-timed or cross-wired stage therefore shows up as another instruction's controls. Branches with zero set and clear sit next to non-branches that have zero set, which separates the zero used for the decision from the zero currently on the input.

// File: rtl/pctl_pkg.sv
`timescale 1ns/1ps
package pctl_pkg;

    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int AOP_W  = 2;
    localparam int ACTL_W = 4;

    localparam logic [OPC_W-1:0] OPC_RR   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STOR = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;

    localparam logic [AOP_W-1:0] AOP_ADD  = 2'b00;
    localparam logic [AOP_W-1:0] AOP_SUB  = 2'b01;
    localparam logic [AOP_W-1:0] AOP_FUNC = 2'b10;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

    localparam logic [ACTL_W-1:0] ACTL_AND = 4'b0000;
    localparam logic [ACTL_W-1:0] ACTL_OR  = 4'b0001;
    localparam logic [ACTL_W-1:0] ACTL_ADD = 4'b0010;
    localparam logic [ACTL_W-1:0] ACTL_SUB = 4'b0110;
    localparam logic [ACTL_W-1:0] ACTL_SLT = 4'b0111;
    localparam logic [ACTL_W-1:0] ACTL_BAD = 4'b1111;

    typedef struct packed {
        logic             dst_rd;
        logic [AOP_W-1:0] alu_op;
        logic             src_imm;
    } ex_ctl_t;

    typedef struct packed {
        logic branch;
        logic rd_en;
        logic wr_en;
    } mem_ctl_t;

    typedef struct packed {
        logic reg_wr;
        logic from_mem;
    } wb_ctl_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } dec_ctl_t;

endpackage

// File: rtl/pctl_main_dec.sv
`timescale 1ns/1ps
module pctl_main_dec
    import pctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_ctl_t         ctl
);

    always_comb begin
        ctl = '0;
        unique case (opcode)
            OPC_RR: begin
                ctl.ex.dst_rd = 1'b1;
                ctl.ex.alu_op = AOP_FUNC;
                ctl.wb.reg_wr = 1'b1;
            end
            OPC_LOAD: begin
                ctl.ex.alu_op   = AOP_ADD;
                ctl.ex.src_imm  = 1'b1;
                ctl.mem.rd_en   = 1'b1;
                ctl.wb.reg_wr   = 1'b1;
                ctl.wb.from_mem = 1'b1;
            end
            OPC_STOR: begin
                ctl.ex.alu_op  = AOP_ADD;
                ctl.ex.src_imm = 1'b1;
                ctl.mem.wr_en  = 1'b1;
            end
            OPC_BEQ: begin
                ctl.ex.alu_op  = AOP_SUB;
                ctl.mem.branch = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/pctl_alu_dec.sv
`timescale 1ns/1ps
module pctl_alu_dec
    import pctl_pkg::*;
(
    input  logic [AOP_W-1:0]  alu_op,
    input  logic [FN_W-1:0]   funct,
    output logic [ACTL_W-1:0] alu_ctl
);

    logic [ACTL_W-1:0] fn_code;

    always_comb begin
        unique case (funct)
            FN_ADD:  fn_code = ACTL_ADD;
            FN_SUB:  fn_code = ACTL_SUB;
            FN_AND:  fn_code = ACTL_AND;
            FN_OR:   fn_code = ACTL_OR;
            FN_SLT:  fn_code = ACTL_SLT;
            default: fn_code = ACTL_BAD;
        endcase
    end

    always_comb begin
        unique case (alu_op)
            AOP_ADD:  alu_ctl = ACTL_ADD;
            AOP_SUB:  alu_ctl = ACTL_SUB;
            AOP_FUNC: alu_ctl = fn_code;
            default:  alu_ctl = ACTL_BAD;
        endcase
    end

endmodule

// File: rtl/pctl_pipe.sv
`timescale 1ns/1ps
module pctl_pipe
    import pctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  dec_ctl_t        id_ctl,
    input  logic [FN_W-1:0] id_funct,
    input  logic            ex_zero,
    output ex_ctl_t         ex_ctl,
    output logic [FN_W-1:0] ex_funct,
    output mem_ctl_t        mem_ctl,
    output logic            mem_zero,
    output wb_ctl_t         wb_ctl
);

    typedef struct packed {
        ex_ctl_t         ex;
        mem_ctl_t        mem;
        wb_ctl_t         wb;
        logic [FN_W-1:0] funct;
    } idex_t;

    typedef struct packed {
        mem_ctl_t mem;
        wb_ctl_t  wb;
        logic     zero;
    } exmem_t;

    typedef struct packed {
        wb_ctl_t wb;
    } memwb_t;

    typedef struct packed {
        idex_t  idex;
        exmem_t exmem;
        memwb_t memwb;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.idex.ex     = id_ctl.ex;
        st_d.idex.mem    = id_ctl.mem;
        st_d.idex.wb     = id_ctl.wb;
        st_d.idex.funct  = id_funct;
        st_d.exmem.mem   = st_q.idex.mem;
        st_d.exmem.wb    = st_q.idex.wb;
        st_d.exmem.zero  = ex_zero;
        st_d.memwb.wb    = st_q.exmem.wb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ex_ctl   = st_q.idex.ex;
    assign ex_funct = st_q.idex.funct;
    assign mem_ctl  = st_q.exmem.mem;
    assign mem_zero = st_q.exmem.zero;
    assign wb_ctl   = st_q.memwb.wb;

    // R3: a memory-stage instruction never reads, writes and branches together
    p_mem_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_ctl.branch, mem_ctl.rd_en, mem_ctl.wr_en}));

    // R11: reset leaves the write-back slot empty on the first edge after release
    p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wb_ctl == '0));

endmodule

// File: rtl/pctl_top.sv
`timescale 1ns/1ps
module pctl_top
    import pctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  id_opcode,
    input  logic [FN_W-1:0]   id_funct,
    input  logic              ex_zero,
    output logic              ex_reg_dst,
    output logic [AOP_W-1:0]  ex_alu_op,
    output logic              ex_alu_src,
    output logic [ACTL_W-1:0] ex_alu_ctl,
    output logic              mem_branch,
    output logic              mem_read,
    output logic              mem_write,
    output logic              mem_pcsrc,
    output logic              wb_reg_write,
    output logic              wb_mem_to_reg
);

    dec_ctl_t        dec_ctl;
    ex_ctl_t         ex_ctl;
    mem_ctl_t        mem_ctl;
    wb_ctl_t         wb_ctl;
    logic [FN_W-1:0] ex_funct;
    logic            mem_zero;

    pctl_main_dec i_main_dec (
        .opcode (id_opcode),
        .ctl    (dec_ctl)
    );

    pctl_pipe i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_ctl   (dec_ctl),
        .id_funct (id_funct),
        .ex_zero  (ex_zero),
        .ex_ctl   (ex_ctl),
        .ex_funct (ex_funct),
        .mem_ctl  (mem_ctl),
        .mem_zero (mem_zero),
        .wb_ctl   (wb_ctl)
    );

    pctl_alu_dec i_alu_dec (
        .alu_op  (ex_ctl.alu_op),
        .funct   (ex_funct),
        .alu_ctl (ex_alu_ctl)
    );

    assign ex_reg_dst    = ex_ctl.dst_rd;
    assign ex_alu_op     = ex_ctl.alu_op;
    assign ex_alu_src    = ex_ctl.src_imm;
    assign mem_branch    = mem_ctl.branch;
    assign mem_read      = mem_ctl.rd_en;
    assign mem_write     = mem_ctl.wr_en;
    assign mem_pcsrc     = mem_ctl.branch & mem_zero;
    assign wb_reg_write  = wb_ctl.reg_wr;
    assign wb_mem_to_reg = wb_ctl.from_mem;

    // cycles since reset release, saturating; only gates the delay checks
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R9: execute outputs are the decode of one cycle earlier
    p_ex_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1) |-> ({ex_reg_dst, ex_alu_op, ex_alu_src} == $past(dec_ctl.ex)));

    // R9: write-back outputs are the decode of three cycles earlier
    p_wb_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> ({wb_reg_write, wb_mem_to_reg} == $past(dec_ctl.wb, 3)));

    // R10: a taken branch is always a branch
    p_pcsrc_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pcsrc |-> mem_branch);

    // R10: the decision uses the zero flag seen while the branch was in execute
    p_pcsrc_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q >= 2'd1) && mem_branch) |-> (mem_pcsrc == $past(ex_zero)));

    // R6: fixed ALU classes ignore the function field
    p_fixed_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_alu_op == 2'b01) |-> (ex_alu_ctl == 4'b0110));

    // R1: a function-coded class always writes rd from two registers
    p_rr_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_alu_op == 2'b10) |-> (ex_reg_dst && !ex_alu_src));

endmodule

// File: tb/test_pctl_top.sv
`timescale 1ns/1ps
module test_pctl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] id_opcode = 6'b111111;
    logic [5:0] id_funct = 6'b000000;
    logic       ex_zero = 1'b0;
    logic       ex_reg_dst, ex_alu_src, mem_branch, mem_read, mem_write;
    logic       mem_pcsrc, wb_reg_write, wb_mem_to_reg;
    logic [1:0] ex_alu_op;
    logic [3:0] ex_alu_ctl;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pctl_top i_pctl_top (
        .clk(clk), .rst_n(rst_n), .id_opcode(id_opcode), .id_funct(id_funct),
        .ex_zero(ex_zero), .ex_reg_dst(ex_reg_dst), .ex_alu_op(ex_alu_op),
        .ex_alu_src(ex_alu_src), .ex_alu_ctl(ex_alu_ctl), .mem_branch(mem_branch),
        .mem_read(mem_read), .mem_write(mem_write), .mem_pcsrc(mem_pcsrc),
        .wb_reg_write(wb_reg_write), .wb_mem_to_reg(wb_mem_to_reg)
    );

    // row: opcode[25:20] funct[19:14] zero[13] ex{dst,op,src}[12:9] alu[8:5] mem{br,rd,wr}[4:2] wb{wr,mem}[1:0]
    localparam int NV = 13;
    localparam logic [25:0] TV [NV] = '{
        {6'b000000, 6'b100000, 1'b0, 4'b1100, 4'b0010, 3'b000, 2'b10},
        {6'b000000, 6'b100010, 1'b1, 4'b1100, 4'b0110, 3'b000, 2'b10},
        {6'b000000, 6'b100100, 1'b0, 4'b1100, 4'b0000, 3'b000, 2'b10},
        {6'b000000, 6'b100101, 1'b1, 4'b1100, 4'b0001, 3'b000, 2'b10},
        {6'b000000, 6'b101010, 1'b0, 4'b1100, 4'b0111, 3'b000, 2'b10},
        {6'b000000, 6'b000111, 1'b0, 4'b1100, 4'b1111, 3'b000, 2'b10},
        {6'b100011, 6'b100100, 1'b0, 4'b0001, 4'b0010, 3'b010, 2'b11},
        {6'b101011, 6'b100010, 1'b1, 4'b0001, 4'b0010, 3'b001, 2'b00},
        {6'b000100, 6'b100101, 1'b1, 4'b0010, 4'b0110, 3'b100, 2'b00},
        {6'b000100, 6'b000000, 1'b0, 4'b0010, 4'b0110, 3'b100, 2'b00},
        {6'b001000, 6'b100000, 1'b1, 4'b0000, 4'b0010, 3'b000, 2'b00},
        {6'b100011, 6'b000000, 1'b1, 4'b0001, 4'b0010, 3'b010, 2'b11},
        {6'b000100, 6'b000000, 1'b1, 4'b0010, 4'b0110, 3'b100, 2'b00}
    };

    function automatic string req_of(input int i);
        case (i)
            0, 1, 2, 3, 4: return "R1 R7";
            5:             return "R7";
            6:             return "R2 R8";
            7:             return "R3 R8";
            8, 9, 12:      return "R4 R6 R10";
            10:            return "R5";
            default:       return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all_zero(input string req);
        chk(req, "ex group", {4'b0, ex_reg_dst, ex_alu_op, ex_alu_src}, 8'h00);
        chk(req, "alu ctl", {4'b0, ex_alu_ctl}, 8'h02);
        chk(req, "mem group", {4'b0, mem_branch, mem_read, mem_write, mem_pcsrc}, 8'h00);
        chk(req, "wb group", {6'b0, wb_reg_write, wb_mem_to_reg}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_all_zero("R11 held");
        rst_n = 1'b1;

        // stream: one instruction per cycle, zero driven for the one in execute
        for (int k = 0; k < NV + 2; k++) begin
            id_opcode = (k < NV) ? TV[k][25:20] : 6'b111111;
            id_funct  = (k < NV) ? TV[k][19:14] : 6'b000000;
            ex_zero   = (k >= 1 && k <= NV) ? TV[k-1][13] : 1'b0;
            @(posedge clk);
            #1;
            if (k < NV) begin
                chk({req_of(k), " R9 ex"}, $sformatf("row %0d ex", k),
                    {4'b0, ex_reg_dst, ex_alu_op, ex_alu_src}, {4'b0, TV[k][12:9]});
                chk({req_of(k), " alu"}, $sformatf("row %0d alu", k),
                    {4'b0, ex_alu_ctl}, {4'b0, TV[k][8:5]});
            end
            if (k >= 1 && k <= NV) begin
                chk({req_of(k-1), " R9 mem"}, $sformatf("row %0d mem", k-1),
                    {5'b0, mem_branch, mem_read, mem_write}, {5'b0, TV[k-1][4:2]});
                chk("R10", $sformatf("row %0d pcsrc", k-1),
                    {7'b0, mem_pcsrc}, {7'b0, TV[k-1][4] & TV[k-1][13]});
            end
            if (k >= 2) begin
                chk({req_of(k-2), " R9 wb"}, $sformatf("row %0d wb", k-2),
                    {6'b0, wb_reg_write, wb_mem_to_reg}, {6'b0, TV[k-2][1:0]});
            end
        end

        // R5: unknown opcode leaves all stages empty after the pipe drains
        chk_all_zero("R5 drained");

        // R8: load with several funct values still adds
        id_opcode = 6'b100011;
        for (int f = 0; f < 4; f++) begin
            id_funct = 6'(f * 13 + 1);
            @(posedge clk);
            #1;
            chk("R8", "load alu ctl", {4'b0, ex_alu_ctl}, 8'h02);
        end

        // R11: asynchronous reset mid-stream clears without a clock edge
        id_opcode = 6'b000100;
        ex_zero = 1'b1;
        @(posedge clk);
        #1;
        id_opcode = 6'b000000;
        id_funct = 6'b101010;
        @(posedge clk);
        #1;
        chk("R10 before reset", "pcsrc", {7'b0, mem_pcsrc}, 8'h01);
        rst_n = 1'b0;
        #0.5;
        chk_all_zero("R11 async");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        id_opcode = 6'b111111;
        @(posedge clk);
        #1;
        chk("R11 R5", "wb after release", {6'b0, wb_reg_write, wb_mem_to_reg}, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule